// File: doc/BRIEF.md
# Four-Bank DDR SDRAM Command Legality Monitor

This block watches the command bus of a four-bank DDR SDRAM and reports illegal commands. On every rising clock edge it decodes the clock-enable, chip-select, row strobe, column strobe, write-enable, bank address and auto-precharge bit into one command. It keeps a state for each bank: idle, open (a row is active) or locked (an auto-precharge is running). It raises a one-cycle error strobe for each kind of violation.

Three static configuration inputs set the timing: the precharge time, the write recovery time and a burst-length code. After a read or write with auto-precharge, the monitor loads a per-bank countdown. The countdown length uses one formula for reads and a longer one for writes, which adds the write recovery time. While the countdown runs, any command to that bank is flagged. A flagged command is treated as if it had not been issued, so the tracked state keeps following the legal command stream.

The monitor sits beside a memory controller in simulation or in an on-chip checker. It drives nothing onto the memory bus.

Top module: `ddr_cmd_checker`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) leaves every bank idle and not locked, with all error strobes low. The precharge-to-mode-register condition counts as met, so a mode register set on the first cycle after reset raises no error.
- R2: An activate (RAS#/CAS#/WE# = L,H,H) to an idle bank opens it, and `bank_open[ba]` is high after that edge. An activate to an already open bank pulses `err_double_act` in the cycle after the command and leaves the state unchanged.
- R3: A read (H,L,H) or write (H,L,L) to a bank that is neither open nor locked pulses `err_not_open` one cycle later. It changes no state.
- R4: A read with `ap`=1 to an open bank issued in cycle n closes the bank and locks it. The lock lasts L = BL/2 + tRP cycles. A command to the bank in cycle n+L-1 pulses `err_lockout` and is ignored. In cycle n+L the bank is idle and accepts commands. The burst-length code `cfg_bl` is 0 for BL2, 1 for BL4, and 2 or 3 for BL8.
- R5: A write with `ap`=1 in cycle n locks its bank for L = BL/2 + 1 + tDPL + tRP cycles, with the same boundary rule as R4.
- R6: A precharge (L,H,L) with `ap`=0 closes only bank `ba`. With `ap`=1 it ignores `ba` and closes all banks. A precharge-all while any bank is locked pulses `err_lockout` and changes nothing.
- R7: A mode register set (L,L,L, either value of `ba`) pulses `err_mrs` if any bank is open or locked. It also pulses `err_mrs` if fewer than tRP cycles separate it from the last accepted precharge. Otherwise it is legal.
- R8: A cycle with `cke` low, `cs_n` high, a no-operation (H,H,H), a burst stop (H,H,L) or an auto refresh (L,L,H) raises no error and changes no bank's open state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; a command is decoded only when high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| ap | input | 1 | Auto-precharge / precharge-all address bit |
| cfg_trp | input | TW | Precharge time in cycles |
| cfg_tdpl | input | TW | Write recovery time in cycles |
| cfg_bl | input | 2 | Burst-length code (0: 2, 1: 4, other: 8) |
| bank_open | output | 4 | Per-bank open flag |
| bank_busy | output | 4 | Per-bank auto-precharge lock flag |
| err_lockout | output | 1 | Command hit a locked bank |
| err_not_open | output | 1 | Read or write to a bank that is not open |
| err_double_act | output | 1 | Activate to an open bank |
| err_mrs | output | 1 | Illegal mode register set |

## Verification
Two pairs of functions can fall in the same cycle. The first is a bank's countdown expiring while a new command targets that bank. The bench issues an activate exactly one cycle before the lock ends, which must be flagged, and then issues it again on the next cycle, which must be accepted and open the bank. The second is a precharge-all while another bank is locked. The bench issues it two cycles after a read with auto-precharge and checks that the error strobe fires and that the other banks stay open. The precharge-time window for a mode register set is probed the same way, on the cycles just inside and just outside the window.

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [1:0]    ba,
  input  logic          ap,
  input  logic [TW-1:0] cfg_trp,
  input  logic [TW-1:0] cfg_tdpl,
  input  logic [1:0]    cfg_bl,
  output logic [3:0]    bank_open,
  output logic [3:0]    bank_busy,
  output logic          err_lockout,
  output logic          err_not_open,
  output logic          err_double_act,
  output logic          err_mrs
);

  localparam int CW = TW + 2;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q [4];
  logic [3:0]    open_q;
  logic [TW-1:0] trp_q;

  logic       sel;
  logic [2:0] rcw;
  assign sel = cke & ~cs_n;
  assign rcw = {ras_n, cas_n, we_n};

  logic is_mrs, is_act, is_rd, is_wr, is_pre;
  assign is_mrs = sel & (rcw == 3'b000);
  assign is_act = sel & (rcw == 3'b011);
  assign is_rd  = sel & (rcw == 3'b101);
  assign is_wr  = sel & (rcw == 3'b100);
  assign is_pre = sel & (rcw == 3'b010);

  always_comb
    for (int i = 0; i < 4; i++) bank_busy[i] = (cnt_q[i] != '0);
  assign bank_open = open_q;

  logic tgt_open, tgt_busy;
  assign tgt_open = open_q[ba];
  assign tgt_busy = bank_busy[ba];

  logic [CW-1:0] bl_half, trp_w, tdpl_w, rd_load, wr_load;
  always_comb
    case (cfg_bl)
      2'd0:    bl_half = CW'(1);
      2'd1:    bl_half = CW'(2);
      default: bl_half = CW'(4);
    endcase
  assign trp_w   = {2'b00, cfg_trp};
  assign tdpl_w  = {2'b00, cfg_tdpl};
  assign rd_load = bl_half + trp_w - ONE;
  assign wr_load = bl_half + tdpl_w + trp_w;

  logic lock_v, nopen_v, dbl_v, mrs_v, accept;
  assign lock_v  = ((is_act | is_rd | is_wr | (is_pre & ~ap)) & tgt_busy)
                 | (is_pre & ap & (|bank_busy));
  assign nopen_v = (is_rd | is_wr) & ~tgt_busy & ~tgt_open;
  assign dbl_v   = is_act & tgt_open;
  assign mrs_v   = is_mrs & ((|open_q) | (|bank_busy) | (trp_q != '0));
  assign accept  = ~(lock_v | nopen_v | dbl_v | mrs_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q         <= '0;
      trp_q          <= '0;
      err_lockout    <= 1'b0;
      err_not_open   <= 1'b0;
      err_double_act <= 1'b0;
      err_mrs        <= 1'b0;
      for (int i = 0; i < 4; i++) cnt_q[i] <= '0;
    end else begin
      err_lockout    <= lock_v;
      err_not_open   <= nopen_v;
      err_double_act <= dbl_v;
      err_mrs        <= mrs_v;
      if (accept && is_pre)
        trp_q <= (cfg_trp == '0) ? '0 : cfg_trp - TW'(1);
      else if (trp_q != '0)
        trp_q <= trp_q - TW'(1);
      for (int i = 0; i < 4; i++) begin
        if (cnt_q[i] != '0) cnt_q[i] <= cnt_q[i] - ONE;
        if (accept) begin
          if (is_act && ba == i[1:0])
            open_q[i] <= 1'b1;
          if ((is_rd || is_wr) && ap && ba == i[1:0] && open_q[i]) begin
            open_q[i] <= 1'b0;
            cnt_q[i]  <= is_wr ? wr_load : rd_load;
          end
          if (is_pre && (ap || ba == i[1:0]))
            open_q[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_bank_chk
    assert_busy_excl_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bank_busy[g] && bank_open[g]));
  end

  assert_double_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && bank_open[ba]) |=> (err_double_act && $stable(bank_open)));

  assert_not_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_rd || is_wr) && !bank_open[ba] && !bank_busy[ba]) |=> err_not_open);

  assert_pre_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && ap && bank_busy == 4'b0) |=> (bank_open == 4'b0));

  assert_mrs_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && bank_open != 4'b0) |=> err_mrs);

  assert_idle_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cke && !cs_n) |=> (!err_lockout && !err_not_open && !err_double_act && !err_mrs
                          && $stable(bank_open)));

  assert_single_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_lockout, err_not_open, err_double_act, err_mrs}));

endmodule

// File: tb/sim_ddr_cmd_checker.sv
`timescale 1ns/1ps
module sim_ddr_cmd_checker;
  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011,
                         C_WR  = 3'b100, C_RD  = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ap = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [3:0] cfg_trp = 4'd3, cfg_tdpl = 4'd2;
  logic [1:0] cfg_bl = 2'd1;
  logic [3:0] bank_open, bank_busy;
  logic err_lockout, err_not_open, err_double_act, err_mrs;
  logic [3:0] ev;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  ddr_cmd_checker #(.TW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .ap(ap), .cfg_trp(cfg_trp), .cfg_tdpl(cfg_tdpl), .cfg_bl(cfg_bl),
    .bank_open(bank_open), .bank_busy(bank_busy), .err_lockout(err_lockout),
    .err_not_open(err_not_open), .err_double_act(err_double_act), .err_mrs(err_mrs));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic raw(input logic k, input logic c, input logic [2:0] code,
                     input logic [1:0] b, input logic a);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = code; ba = b; ap = a;
    @(posedge clk); #1;
    ev = {err_lockout, err_not_open, err_double_act, err_mrs};
    cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; ap = 1'b0;
  endtask

  task automatic issue(input logic [2:0] code, input logic [1:0] b, input logic a);
    raw(1'b1, 1'b0, code, b, a);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(C_NOP, 2'd0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_trp = 4'd3; cfg_tdpl = 4'd2; cfg_bl = 2'd1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 open after reset", 8'(bank_open), 8'h0);
    chk("R1 busy after reset", 8'(bank_busy), 8'h0);
    issue(C_MRS, 2'd1, 1'b0);
    chk("R1 mrs right after reset", 8'(ev), 8'h0);
  endtask

  task automatic t_activate();
    do_reset();
    issue(C_ACT, 2'd1, 1'b0);
    chk("R2 activate opens bank1", 8'(bank_open), 8'h2);
    chk("R2 activate no error", 8'(ev), 8'h0);
    issue(C_ACT, 2'd1, 1'b0);
    chk("R2 double activate strobe", 8'(ev), 8'h2);
    chk("R2 double activate state", 8'(bank_open), 8'h2);
  endtask

  task automatic t_not_open();
    do_reset();
    issue(C_RD, 2'd2, 1'b0);
    chk("R3 read idle bank", 8'(ev), 8'h4);
    issue(C_WR, 2'd3, 1'b1);
    chk("R3 write idle bank", 8'(ev), 8'h4);
    chk("R3 state untouched", 8'({bank_open, bank_busy}), 8'h0);
  endtask

  task automatic t_rd_ap();
    do_reset();
    issue(C_ACT, 2'd1, 1'b0);
    issue(C_RD, 2'd1, 1'b1);
    chk("R4 read-ap closes and locks", 8'({bank_open, bank_busy}), 8'h02);
    nops(3);
    issue(C_ACT, 2'd1, 1'b0);
    chk("R4 act at n+L-1 locked", 8'(ev), 8'h8);
    chk("R4 bank idle at n+L", 8'({bank_open, bank_busy}), 8'h00);
    issue(C_ACT, 2'd1, 1'b0);
    chk("R4 act at n+L accepted", 8'({ev, bank_open}), 8'h02);
    cfg_bl = 2'd2;
    issue(C_RD, 2'd1, 1'b1);
    nops(5);
    issue(C_ACT, 2'd1, 1'b0);
    chk("R4 BL8 act at n+L-1 locked", 8'(ev), 8'h8);
    issue(C_ACT, 2'd1, 1'b0);
    chk("R4 BL8 act at n+L accepted", 8'({ev, bank_open}), 8'h02);
  endtask

  task automatic t_wr_ap();
    do_reset();
    issue(C_ACT, 2'd2, 1'b0);
    issue(C_WR, 2'd2, 1'b1);
    chk("R5 write-ap locks", 8'(bank_busy), 8'h4);
    nops(6);
    issue(C_PRE, 2'd2, 1'b0);
    chk("R5 precharge at n+L-1 locked", 8'(ev), 8'h8);
    issue(C_ACT, 2'd2, 1'b0);
    chk("R5 act at n+L accepted", 8'({ev, bank_open}), 8'h04);
  endtask

  task automatic t_precharge();
    do_reset();
    issue(C_ACT, 2'd0, 1'b0);
    issue(C_ACT, 2'd1, 1'b0);
    issue(C_ACT, 2'd2, 1'b0);
    issue(C_PRE, 2'd0, 1'b0);
    chk("R6 single precharge", 8'(bank_open), 8'h6);
    issue(C_PRE, 2'd0, 1'b1);
    chk("R6 precharge all", 8'(bank_open), 8'h0);
    issue(C_ACT, 2'd3, 1'b0);
    issue(C_RD, 2'd3, 1'b1);
    issue(C_ACT, 2'd0, 1'b0);
    issue(C_PRE, 2'd0, 1'b1);
    chk("R6 precharge all while locked", 8'({ev, bank_open}), 8'h81);
  endtask

  task automatic t_mrs();
    do_reset();
    issue(C_ACT, 2'd0, 1'b0);
    issue(C_MRS, 2'd0, 1'b0);
    chk("R7 mrs with open bank", 8'(ev), 8'h1);
    issue(C_PRE, 2'd0, 1'b0);
    issue(C_MRS, 2'd1, 1'b0);
    chk("R7 mrs at p+1", 8'(ev), 8'h1);
    issue(C_MRS, 2'd0, 1'b0);
    chk("R7 mrs at p+2", 8'(ev), 8'h1);
    issue(C_MRS, 2'd0, 1'b0);
    chk("R7 mrs at p+tRP legal", 8'(ev), 8'h0);
    issue(C_ACT, 2'd2, 1'b0);
    issue(C_RD, 2'd2, 1'b1);
    issue(C_MRS, 2'd0, 1'b0);
    chk("R7 mrs with locked bank", 8'(ev), 8'h1);
  endtask

  task automatic t_ignored();
    do_reset();
    issue(C_ACT, 2'd2, 1'b0);
    raw(1'b0, 1'b0, C_ACT, 2'd2, 1'b0);
    chk("R8 cke low activate", 8'({ev, bank_open}), 8'h04);
    raw(1'b1, 1'b1, C_PRE, 2'd2, 1'b1);
    chk("R8 deselected precharge", 8'({ev, bank_open}), 8'h04);
    issue(C_BST, 2'd2, 1'b0);
    chk("R8 burst stop", 8'({ev, bank_open}), 8'h04);
    issue(C_REF, 2'd0, 1'b0);
    chk("R8 auto refresh", 8'({ev, bank_open}), 8'h04);
    issue(C_NOP, 2'd2, 1'b1);
    chk("R8 no operation", 8'({ev, bank_open}), 8'h04);
  endtask

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_activate();
    t_not_open();
    t_rd_ap();
    t_wr_ap();
    t_precharge();
    t_mrs();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule